// File: doc/BRIEF.md
# Shared Video Memory Host Write Port

This block lets a host on a narrow 8-bit parallel port place bytes into video memory that it shares with the raster fetcher. The host writes one byte in three strobed steps: the upper address byte, then the lower address byte, then the data byte. The block captures each one on the rising edge of the strobe. After the data byte it raises a busy flag. It holds the write pending until the memory is free, then issues a single write cycle and drops busy.

The raster fetcher tells the block, cycle by cycle, when it owns the memory for a shift-register load (`fetch_slot`) and when the display is in blanking (`blank`). Within each byte period the memory time is split between the fetcher and this port. The host write only goes into cycles the fetcher does not claim, or into any cycle while blanking is active, so the host's wait is bounded by one byte-fetch period. An optional auto-increment mode advances the captured address after each committed byte and keeps the sequencer at the data step. A run of consecutive bytes then needs only one strobe per byte.

Top module: `vram_host_port`

## Requirements
- R1: After reset, `busy` and `ram_we` are low and the sequencer expects the upper address byte first.
- R2: The three accepted strobes, in order, capture address bits [14:8], address bits [7:0] and the data byte. The commit presents `ram_addr` = {upper[6:0], lower} and `ram_wdata` = the data byte. Both stay stable while the write is pending.
- R3: Bit 7 of the upper address byte is ignored.
- R4: `host_stb` passes through a two-flop synchronizer and only its rising edge counts. A strobe held high for many cycles captures one byte.
- R5: `busy` rises after the data byte is captured and stays high until the commit cycle. It falls on the clock after the first free cycle. `ram_we` is never high while `busy` is low.
- R6: `ram_we` is asserted only in a cycle where `fetch_slot` is low or `blank` is high. A write pending while the fetcher holds the memory outside blanking waits.
- R7: While `blank` is high, a pending write commits in the first cycle, whatever the state of `fetch_slot`.
- R8: Each captured data byte produces exactly one `ram_we` pulse of one clock.
- R9: With `auto_inc` high at the commit, the address advances by one and wraps from 0x7FFF to 0x0000. The sequencer stays at the data step, so the next strobe alone writes the next byte.
- R10: With `auto_inc` low, the sequencer returns to the upper-address step after the data byte.
- R11: Strobes that arrive while `busy` is high are ignored and do not move the sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory and pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_data | input | 8 | Byte presented by the host |
| host_stb | input | 1 | Asynchronous host strobe, rising edge captures `host_data` |
| auto_inc | input | 1 | Selects address auto-increment after each committed byte |
| busy | output | 1 | High while a captured byte waits to be written |
| fetch_slot | input | 1 | High when the raster fetcher owns memory this cycle |
| blank | input | 1 | High during horizontal or vertical blanking |
| ram_we | output | 1 | Single-cycle memory write enable |
| ram_addr | output | 15 | Memory write address |
| ram_wdata | output | 8 | Memory write data |

## Verification
A pending commit and a fetcher slot claim can fall in the same cycle. The bench provokes this by holding `fetch_slot` high with blanking off, by toggling it every cycle, and by raising `blank` while the fetcher still claims the cycle. In each case it records every `ram_we` cycle together with the slot state seen in that cycle. A write during a claimed non-blank cycle counts as a failure, as does a busy run longer than two cycles under the alternating pattern. A host strobe and a pending commit can also overlap. The bench sends address strobes while a write is held off, then checks that the next full transaction lands at its own address.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

    // Order of the host transfer steps; the sequence itself is behaviour.
    typedef enum logic [1:0] {
        STEP_ADDR_HI = 2'd0,
        STEP_ADDR_LO = 2'd1,
        STEP_DATA    = 2'd2
    } host_step_e;

endpackage

// File: rtl/vhp_strobe_sync.sv
module vhp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_rise
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                st_d       = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], strobe_async};
                st_d.prev  = st_q.chain[LAST];
            end
        end else begin : g_single
            always_comb begin
                st_d       = st_q;
                st_d.chain = strobe_async;
                st_d.prev  = st_q.chain[LAST];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_rise = st_q.chain[LAST] & ~st_q.prev;

endmodule

// File: rtl/vhp_sequencer.sv
module vhp_sequencer
    import vhp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_rise,
    input  logic [DATA_W-1:0] host_data,
    input  logic              auto_inc,
    input  logic              busy,
    input  logic              commit,
    output logic              launch,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        host_step_e        step;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    assign accept = strobe_rise & ~busy;
    assign launch = accept & (seq_q.step == STEP_DATA);

    always_comb begin
        seq_d = seq_q;
        if (accept) begin
            unique case (seq_q.step)
                STEP_ADDR_HI: begin
                    seq_d.addr[ADDR_W-1:DATA_W] = host_data[HI_W-1:0];
                    seq_d.step                  = STEP_ADDR_LO;
                end
                STEP_ADDR_LO: begin
                    seq_d.addr[DATA_W-1:0] = host_data;
                    seq_d.step             = STEP_DATA;
                end
                STEP_DATA: begin
                    seq_d.wdata = host_data;
                    seq_d.step  = auto_inc ? STEP_DATA : STEP_ADDR_HI;
                end
                default: begin
                    seq_d.step = STEP_ADDR_HI;
                end
            endcase
        end
        if (commit && auto_inc) begin
            seq_d.addr = seq_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.step  <= STEP_ADDR_HI;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr  = seq_q.addr;
    assign wdata = seq_q.wdata;

endmodule

// File: rtl/vhp_slot_arbiter.sv
module vhp_slot_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic fetch_slot,
    input  logic blank,
    output logic busy,
    output logic ram_we
);

    typedef struct packed {
        logic pending;
    } arb_t;

    arb_t arb_d, arb_q;
    logic slot_free;

    assign slot_free = blank | ~fetch_slot;
    assign ram_we    = arb_q.pending & slot_free;
    assign busy      = arb_q.pending;

    always_comb begin
        arb_d = arb_q;
        if (launch) begin
            arb_d.pending = 1'b1;
        end else if (ram_we) begin
            arb_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q <= '0;
        end else begin
            arb_q <= arb_d;
        end
    end

endmodule

// File: rtl/vram_host_port.sv
module vram_host_port #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_stb,
    input  logic              auto_inc,
    output logic              busy,
    input  logic              fetch_slot,
    input  logic              blank,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);

    logic stb_rise;
    logic launch;

    vhp_strobe_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_async(host_stb),
        .strobe_rise (stb_rise)
    );

    vhp_sequencer #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_rise(stb_rise),
        .host_data  (host_data),
        .auto_inc   (auto_inc),
        .busy       (busy),
        .commit     (ram_we),
        .launch     (launch),
        .addr       (ram_addr),
        .wdata      (ram_wdata)
    );

    vhp_slot_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .fetch_slot(fetch_slot),
        .blank     (blank),
        .busy      (busy),
        .ram_we    (ram_we)
    );

endmodule

// File: rtl/vhp_checker.sv
module vhp_checker #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_inc,
    input logic              busy,
    input logic              fetch_slot,
    input logic              blank,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata
);

    AST_WE_IN_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (blank || !fetch_slot)); // R6

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R8

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ram_we); // R5

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (blank || !fetch_slot)) |=> !busy); // R5

    AST_BLANK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blank) |-> ram_we); // R7

    AST_PENDING_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ram_we) |=> ($stable(ram_addr) && $stable(ram_wdata))); // R2

    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && auto_inc) |=> (ram_addr == ADDR_W'($past(ram_addr) + ADDR_W'(1)))); // R9

endmodule

bind vram_host_port vhp_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_inc  (auto_inc),
    .busy      (busy),
    .fetch_slot(fetch_slot),
    .blank     (blank),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
);

// File: tb/vram_host_port_test.sv
module vram_host_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_DLY = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_data = '0;
    logic        host_stb = 1'b0;
    logic        auto_inc = 1'b0;
    logic        busy;
    logic        fetch_slot = 1'b0;
    logic        blank = 1'b0;
    logic        ram_we;
    logic [14:0] ram_addr;
    logic [7:0]  ram_wdata;

    int checks = 0;
    int fails = 0;
    int fetch_mode = 0;   // 0: never claimed, 1: every other cycle, 2: always claimed

    int          wr_count = 0;
    int          bad_slot = 0;
    int          busy_run = 0;
    int          max_busy_run = 0;
    int          we_run = 0;
    int          max_we_run = 0;
    logic [14:0] last_addr = '0;
    logic [7:0]  last_data = '0;

    vram_host_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_data (host_data),
        .host_stb  (host_stb),
        .auto_inc  (auto_inc),
        .busy      (busy),
        .fetch_slot(fetch_slot),
        .blank     (blank),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        case (fetch_mode)
            1:       fetch_slot = ~fetch_slot;
            2:       fetch_slot = 1'b1;
            default: fetch_slot = 1'b0;
        endcase
    end

    always begin
        @(negedge clk);
        #(SAMPLE_DLY);
        if (rst_n) begin
            if (ram_we) begin
                wr_count++;
                last_addr = ram_addr;
                last_data = ram_wdata;
                if (fetch_slot && !blank) bad_slot++;
                we_run++;
                if (we_run > max_we_run) max_we_run = we_run;
            end else begin
                we_run = 0;
            end
            if (busy) begin
                busy_run++;
                if (busy_run > max_busy_run) max_busy_run = busy_run;
            end else begin
                busy_run = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic send_byte(input logic [7:0] b, input int hold);
        @(negedge clk);
        host_data = b;
        host_stb  = 1'b1;
        repeat (hold) @(negedge clk);
        host_stb  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_txn(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
        send_byte(hi, 4);
        send_byte(lo, 4);
        send_byte(d, 4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #(SAMPLE_DLY);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 ram_we after reset", int'(ram_we), 0);
        check("R1 no writes after reset", wr_count, 0);
    endtask

    task automatic t_basic();
        int w0;
        fetch_mode = 0;
        w0 = wr_count;
        send_txn(8'h12, 8'h34, 8'hAB);
        check("R1 R2 address of first transaction", int'(last_addr), 'h1234);
        check("R2 data of first transaction", int'(last_data), 'hAB);
        check("R8 one write per byte", wr_count, w0 + 1);
        check("R8 write pulse length", max_we_run, 1);
        send_txn(8'h03, 8'hC4, 8'h5A);
        check("R10 second transaction address", int'(last_addr), 'h03C4);
        check("R10 second transaction data", int'(last_data), 'h5A);
    endtask

    task automatic t_top_bit();
        send_txn(8'hFF, 8'h00, 8'h77);
        check("R3 upper bit ignored", int'(last_addr), 'h7F00);
    endtask

    task automatic t_held_strobe();
        int w0;
        w0 = wr_count;
        send_byte(8'h01, 4);
        send_byte(8'h02, 4);
        send_byte(8'h99, 30);
        check("R4 held strobe writes once", wr_count, w0 + 1);
        check("R4 held strobe address", int'(last_addr), 'h0102);
        send_txn(8'h04, 8'h05, 8'h06);
        check("R4 next transaction after held strobe", int'(last_addr), 'h0405);
    endtask

    task automatic t_blocked_then_blank();
        int w0;
        fetch_mode = 2;
        blank = 1'b0;
        repeat (2) @(negedge clk);
        w0 = wr_count;
        send_txn(8'h2A, 8'h10, 8'hC3);
        repeat (20) @(negedge clk);
        #(SAMPLE_DLY);
        check("R5 busy held while slots claimed", int'(busy), 1);
        check("R6 no write during claimed slots", wr_count, w0);
        // strobes while busy must be dropped
        send_byte(8'h11, 4);
        send_byte(8'h22, 4);
        @(negedge clk);
        blank = 1'b1;
        @(negedge clk);
        #(SAMPLE_DLY);
        check("R7 commit in blanking", wr_count, w0 + 1);
        check("R7 busy cleared after blanking commit", int'(busy), 0);
        check("R7 blanking commit address", int'(last_addr), 'h2A10);
        check("R2 blanking commit data", int'(last_data), 'hC3);
        blank = 1'b0;
        fetch_mode = 0;
        send_txn(8'h05, 8'h06, 8'h07);
        check("R11 strobes during busy ignored", int'(last_addr), 'h0506);
        check("R11 data after ignored strobes", int'(last_data), 'h07);
    endtask

    task automatic t_alternating();
        int w0;
        fetch_mode = 1;
        w0 = wr_count;
        max_busy_run = 0;
        send_txn(8'h10, 8'h20, 8'h30);
        send_txn(8'h11, 8'h21, 8'h31);
        send_txn(8'h12, 8'h22, 8'h32);
        check("R6 writes under alternating slots", wr_count, w0 + 3);
        check("R6 no write in claimed slot", bad_slot, 0);
        check("R5 busy bounded by one byte period", int'(max_busy_run <= 2), 1);
        check("R2 last alternating address", int'(last_addr), 'h1222);
        fetch_mode = 0;
    endtask

    task automatic t_auto_inc();
        @(negedge clk);
        auto_inc = 1'b1;
        send_txn(8'h7F, 8'hFE, 8'h01);
        check("R9 first auto address", int'(last_addr), 'h7FFE);
        send_byte(8'h02, 4);
        check("R9 data-only strobe advances", int'(last_addr), 'h7FFF);
        send_byte(8'h03, 4);
        check("R9 address wraps", int'(last_addr), 'h0000);
        check("R9 wrapped data", int'(last_data), 'h03);
        @(negedge clk);
        auto_inc = 1'b0;
        send_byte(8'h04, 4);
        check("R9 last auto step address", int'(last_addr), 'h0001);
        send_txn(8'h08, 8'h09, 8'h0A);
        check("R10 back to upper-address step", int'(last_addr), 'h0809);
        check("R6 no claimed-slot writes overall", bad_slot, 0);
        check("R8 pulse length overall", max_we_run, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_top_bit();
        t_held_strobe();
        t_blocked_then_blank();
        t_alternating();
        t_auto_inc();
        repeat (4) @(negedge clk);
        report();
        $finish;
    end

endmodule